// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits in the I/O space of a host bridge and turns accesses to a pair of ports into configuration-space transactions. The first port is a 32-bit selector register at a base I/O address. It holds an enable bit and the bus, device/function and dword register that the next data access addresses. A data window of four byte ports, starting four bytes above the base, then becomes a configuration read or write on a downstream request port. The byte enables and the data lanes of that request follow from the offset inside the window and from the access size.

An I/O master presents an access and holds it until `io_ready` pulses. With the pulse, `io_claim` says whether the decoder served the access itself. When `io_claim` is low, the access is left to the ordinary I/O path. This happens for narrow accesses to the selector ports, for the data window while the enable bit is clear, and for any other port. A configuration access waits on the downstream `cfg_ack`. If the responder flags that no device answered, the read returns all ones on the requested lanes.

Top module: `cfg_port_decoder`

## Requirements
- R1: A 32-bit write (size code 2) to port BASE (default 0xCF8) loads the selector register. Bits 30:24 and 1:0 are stored as zero, so writing 0x80000000 reads back as 0x80000000 and writing 0xFFFFFFFF reads back as 0x80FFFFFC. A 32-bit read of BASE is claimed and returns the register.
- R2: Byte (size code 0) and word (size code 1) accesses to ports BASE to BASE+3, reads included, are not claimed and leave the selector register unchanged.
- R3: Accesses to the data window (BASE+4 to BASE+7) are claimed only while selector bit 31 is set. Otherwise they are not claimed and issue no downstream request.
- R4: A downstream request carries bus = selector[23:16], devfn = selector[15:8] and register = selector[7:2].
- R5: With window offset k = port[1:0], the byte enables are 1<<k for a byte access, 0011<<k for a word access with k in 0..2, and 1111 for a dword access at k = 0.
- R6: A word access at k = 3, a dword access at k ≠ 0 and size code 3 are claimed with `io_err` set. They issue no downstream request and return zero data.
- R7: Write data is taken from the low bytes of `io_wdata`, masked to the access width and shifted up by 8*k onto the downstream lanes.
- R8: Read data is shifted down by 8*k and masked to the access width. The bits above the width are zero.
- R9: A downstream read completed with `cfg_nf` returns all ones over the access width.
- R10: After reset the selector register is zero (disabled), and neither `cfg_req` nor `io_ready` is asserted.
- R11: `cfg_req` and its fields stay stable until `cfg_ack`. `io_ready` is a single-cycle pulse for each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | I/O access pending, held until io_ready |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | PORT_W | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Write data, low-aligned |
| io_ready | output | 1 | Access complete (one cycle) |
| io_claim | output | 1 | Access served by this decoder |
| io_err | output | 1 | Unsupported alignment or size |
| io_rdata | output | 32 | Read data, low-aligned |
| cfg_req | output | 1 | Configuration request pending |
| cfg_wr | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-steered write data |
| cfg_ack | input | 1 | Request completed |
| cfg_rdata | input | 32 | Read data on the dword lanes |
| cfg_nf | input | 1 | No device responded |

## Verification
The hardest case to reach from the ports is a narrow write that lands on a selector byte. An example is a byte write to BASE+3 that in a real probe sequence would set the enable bit. It must leave the register untouched and must not be claimed. The stimulus loads a known selector value, issues byte and word writes across the selector ports, and then reads the register back with a full-width read. It then clears the enable bit and repeats accesses to the data window to show that they fall through without a downstream request. A second hard corner is the completion of a read for which no device answered. The bench's responder model raises `cfg_nf` on chosen vectors so that the all-ones result can be checked at both word and dword width.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } io_size_e;

    typedef enum logic [2:0] {
        K_PASS,
        K_SEL_WR,
        K_SEL_RD,
        K_CFG,
        K_BAD
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CFG,
        S_RESP
    } fsm_e;

    // Bits of the selector register that are kept; the rest read as zero.
    localparam logic [31:0] SEL_KEEP = 32'h80FF_FFFC;

    typedef struct packed {
        fsm_e        st;
        logic [31:0] sel;
        logic        req_wr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [1:0]  off;
        logic [1:0]  size;
        logic        ready;
        logic        claim;
        logic        err;
        logic [31:0] rdata;
    } regs_t;

    function automatic logic [31:0] width_mask(input logic [1:0] size);
        case (size)
            SZ_BYTE: width_mask = 32'h0000_00FF;
            SZ_WORD: width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
    import cfgp_pkg::*;
#(
    parameter int                PORT_W    = 16,
    parameter logic [PORT_W-1:0] BASE_PORT = 'hCF8
) (
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic              enable,
    output acc_kind_e         kind,
    output logic [3:0]        be
);
    localparam logic [PORT_W-1:0] WIN_PORT = BASE_PORT + PORT_W'(4);

    logic [1:0] off;
    logic       in_win;

    assign off    = port[1:0];
    assign in_win = (port[PORT_W-1:2] == WIN_PORT[PORT_W-1:2]);

    always_comb begin
        kind = K_PASS;
        be   = 4'b0000;
        if (port == BASE_PORT && size == SZ_DWORD) begin
            kind = wr ? K_SEL_WR : K_SEL_RD;
        end else if (in_win && enable) begin
            case (size)
                SZ_BYTE: begin
                    kind = K_CFG;
                    be   = 4'b0001 << off;
                end
                SZ_WORD: begin
                    if (off == 2'd3) begin
                        kind = K_BAD;
                    end else begin
                        kind = K_CFG;
                        be   = 4'b0011 << off;
                    end
                end
                SZ_DWORD: begin
                    if (off == 2'd0) begin
                        kind = K_CFG;
                        be   = 4'b1111;
                    end else begin
                        kind = K_BAD;
                    end
                end
                default: kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/cfgp_lanes.sv
module cfgp_lanes
    import cfgp_pkg::*;
(
    input  logic [1:0]  w_off,
    input  logic [1:0]  w_size,
    input  logic [31:0] w_in,
    output logic [31:0] w_out,
    input  logic [1:0]  r_off,
    input  logic [1:0]  r_size,
    input  logic [31:0] r_in,
    input  logic        r_nf,
    output logic [31:0] r_out
);
    logic [31:0] w_mask;
    logic [31:0] r_mask;

    always_comb begin
        w_mask = width_mask(w_size);
        r_mask = width_mask(r_size);
        w_out  = (w_in & w_mask) << {w_off, 3'b000};
        r_out  = r_nf ? r_mask : ((r_in >> {r_off, 3'b000}) & r_mask);
    end

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import cfgp_pkg::*;
#(
    parameter int                PORT_W    = 16,
    parameter logic [PORT_W-1:0] BASE_PORT = 'hCF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size,
    input  logic [31:0]       io_wdata,
    output logic              io_ready,
    output logic              io_claim,
    output logic              io_err,
    output logic [31:0]       io_rdata,
    output logic              cfg_req,
    output logic              cfg_wr,
    output logic [7:0]        cfg_bus,
    output logic [7:0]        cfg_devfn,
    output logic [5:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata,
    input  logic              cfg_nf
);
    regs_t       q, d;
    acc_kind_e   kind;
    logic [3:0]  dec_be;
    logic [31:0] lane_w;
    logic [31:0] lane_r;

    cfgp_decode #(
        .PORT_W    (PORT_W),
        .BASE_PORT (BASE_PORT)
    ) u_decode (
        .port   (io_port),
        .size   (io_size),
        .wr     (io_wr),
        .enable (q.sel[31]),
        .kind   (kind),
        .be     (dec_be)
    );

    cfgp_lanes u_lanes (
        .w_off  (io_port[1:0]),
        .w_size (io_size),
        .w_in   (io_wdata),
        .w_out  (lane_w),
        .r_off  (q.off),
        .r_size (q.size),
        .r_in   (cfg_rdata),
        .r_nf   (cfg_nf),
        .r_out  (lane_r)
    );

    always_comb begin
        d       = q;
        d.ready = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (io_req) begin
                    d.st    = S_RESP;
                    d.claim = 1'b1;
                    d.err   = 1'b0;
                    d.rdata = '0;
                    case (kind)
                        K_PASS:   d.claim = 1'b0;
                        K_SEL_WR: d.sel   = io_wdata & SEL_KEEP;
                        K_SEL_RD: d.rdata = q.sel;
                        K_BAD:    d.err   = 1'b1;
                        K_CFG: begin
                            d.st     = S_CFG;
                            d.req_wr = io_wr;
                            d.be     = dec_be;
                            d.wdata  = lane_w;
                            d.off    = io_port[1:0];
                            d.size   = io_size;
                        end
                        default: d.err = 1'b1;
                    endcase
                    d.ready = (d.st == S_RESP);
                end
            end
            S_CFG: begin
                if (cfg_ack) begin
                    d.st    = S_RESP;
                    d.ready = 1'b1;
                    d.rdata = q.req_wr ? 32'h0 : lane_r;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign io_ready  = q.ready;
    assign io_claim  = q.claim;
    assign io_err    = q.err;
    assign io_rdata  = q.rdata;
    assign cfg_req   = (q.st == S_CFG);
    assign cfg_wr    = q.req_wr;
    assign cfg_bus   = q.sel[23:16];
    assign cfg_devfn = q.sel[15:8];
    assign cfg_reg   = q.sel[7:2];
    assign cfg_be    = q.be;
    assign cfg_wdata = q.wdata;

    AST_SEL_ONLY_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.st == S_IDLE && io_req && io_wr && io_size == SZ_DWORD && io_port == BASE_PORT)
        |=> $stable(q.sel)); // R2

    AST_SEL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready && io_claim && !io_err && $past(io_port == BASE_PORT && !io_wr)
        |-> (io_rdata & ~SEL_KEEP) == 32'h0); // R1

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> q.sel[31]); // R3

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_be) && $stable(cfg_wdata)
                                && $stable(cfg_wr)); // R11

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready); // R11

    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $countones(cfg_be) inside {1, 2, 4}); // R5

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready && io_err |-> !cfg_req && io_rdata == 32'h0); // R6

    AST_NF_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready && $past(cfg_req && cfg_ack && cfg_nf && !cfg_wr)
        |-> io_rdata[7:0] == 8'hFF); // R9

endmodule

// File: tb/cfg_port_decoder_tb.sv
module cfg_port_decoder_tb;

    typedef struct packed {
        logic        wr;
        logic [15:0] port;
        logic [1:0]  sz;
        logic [31:0] wdata;
        logic [31:0] drd;
        logic        nf;
        logic        eclaim;
        logic        eerr;
        logic [31:0] erd;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 25;
    // Tags: R1 selector load, R2 narrow selector access, R3 enable, R5 byte
    // enables, R6 misaligned, R7 write steering, R8 read steering, R9 no device.
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'hCF8, 2'd2, 32'h8012_3404, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         4'h0, 32'h0,         4'd1},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         32'h0,         1'b0, 1'b1, 1'b0, 32'h8012_3404, 4'h0, 32'h0,         4'd1},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         32'h1122_3344, 1'b0, 1'b1, 1'b0, 32'h1122_3344, 4'hF, 32'h0,         4'd5},
        '{1'b0, 16'hCFE, 2'd0, 32'h0,         32'hAABB_CCDD, 1'b0, 1'b1, 1'b0, 32'h0000_00BB, 4'h4, 32'h0,         4'd8},
        '{1'b0, 16'hCFD, 2'd1, 32'h0,         32'hAABB_CCDD, 1'b0, 1'b1, 1'b0, 32'h0000_BBCC, 4'h6, 32'h0,         4'd8},
        '{1'b1, 16'hCFF, 2'd0, 32'hFFFF_FF5A, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         4'h8, 32'h5A00_0000, 4'd7},
        '{1'b1, 16'hCFE, 2'd1, 32'h0000_1234, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         4'hC, 32'h1234_0000, 4'd7},
        '{1'b0, 16'hCFC, 2'd1, 32'h0,         32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_FFFF, 4'h3, 32'h0,         4'd9},
        '{1'b0, 16'hCFF, 2'd1, 32'h0,         32'h0,         1'b0, 1'b1, 1'b1, 32'h0,         4'h0, 32'h0,         4'd6},
        '{1'b1, 16'hCFD, 2'd2, 32'h0,         32'h0,         1'b0, 1'b1, 1'b1, 32'h0,         4'h0, 32'h0,         4'd6},
        '{1'b1, 16'hCFB, 2'd0, 32'h0000_0001, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0,         4'd2},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         32'h0,         1'b0, 1'b1, 1'b0, 32'h8012_3404, 4'h0, 32'h0,         4'd2},
        '{1'b1, 16'hCF8, 2'd1, 32'h0000_FFFF, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0,         4'd2},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         32'h0,         1'b0, 1'b1, 1'b0, 32'h8012_3404, 4'h0, 32'h0,         4'd2},
        '{1'b0, 16'hCF8, 2'd0, 32'h0,         32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0,         4'd2},
        '{1'b1, 16'hCF8, 2'd2, 32'hFFFF_FFFF, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         4'h0, 32'h0,         4'd1},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         32'h0,         1'b0, 1'b1, 1'b0, 32'h80FF_FFFC, 4'h0, 32'h0,         4'd1},
        '{1'b1, 16'hCF8, 2'd2, 32'h0000_0000, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         4'h0, 32'h0,         4'd3},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         32'h1234_5678, 1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0,         4'd3},
        '{1'b1, 16'hCFE, 2'd0, 32'h0000_0077, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,         4'h0, 32'h0,         4'd3},
        '{1'b1, 16'hCF8, 2'd2, 32'h8000_0000, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,         4'h0, 32'h0,         4'd1},
        '{1'b0, 16'hCF8, 2'd2, 32'h0,         32'h0,         1'b0, 1'b1, 1'b0, 32'h8000_0000, 4'h0, 32'h0,         4'd1},
        '{1'b0, 16'hCFC, 2'd3, 32'h0,         32'h0,         1'b0, 1'b1, 1'b1, 32'h0,         4'h0, 32'h0,         4'd6},
        '{1'b0, 16'hCFC, 2'd0, 32'h0,         32'h0000_00A7, 1'b0, 1'b1, 1'b0, 32'h0000_00A7, 4'h1, 32'h0,         4'd5},
        '{1'b0, 16'hCFC, 2'd2, 32'h0,         32'h0,         1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 4'hF, 32'h0,         4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready, io_claim, io_err;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_wr;
    logic [7:0]  cfg_bus, cfg_devfn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic        cfg_nf = 1'b0;

    logic [31:0] dev_rd = '0;
    logic        dev_nf = 1'b0;
    int          cfg_count = 0;
    logic        cap_wr = 1'b0;
    logic [3:0]  cap_be = '0;
    logic [31:0] cap_wd = '0;
    logic [21:0] cap_tgt = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cfg_port_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_req    (io_req),
        .io_wr     (io_wr),
        .io_port   (io_port),
        .io_size   (io_size),
        .io_wdata  (io_wdata),
        .io_ready  (io_ready),
        .io_claim  (io_claim),
        .io_err    (io_err),
        .io_rdata  (io_rdata),
        .cfg_req   (cfg_req),
        .cfg_wr    (cfg_wr),
        .cfg_bus   (cfg_bus),
        .cfg_devfn (cfg_devfn),
        .cfg_reg   (cfg_reg),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_ack   (cfg_ack),
        .cfg_rdata (cfg_rdata),
        .cfg_nf    (cfg_nf)
    );

    // Responder model: acknowledges one cycle after seeing a request.
    always @(negedge clk) begin
        if (cfg_req && !cfg_ack) begin
            cfg_ack   <= 1'b1;
            cfg_rdata <= dev_rd;
            cfg_nf    <= dev_nf;
            cfg_count <= cfg_count + 1;
            cap_wr    <= cfg_wr;
            cap_be    <= cfg_be;
            cap_wd    <= cfg_wdata;
            cap_tgt   <= {cfg_bus, cfg_devfn, cfg_reg};
        end else begin
            cfg_ack   <= 1'b0;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_io(input logic wr, input logic [15:0] port, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [31:0] drd, input logic nf,
                         output logic got, output logic claim, output logic err,
                         output logic [31:0] rd, output int ncfg);
        int c0;
        @(negedge clk);
        dev_rd   = drd;
        dev_nf   = nf;
        c0       = cfg_count;
        io_wr    = wr;
        io_port  = port;
        io_size  = sz;
        io_wdata = wd;
        io_req   = 1'b1;
        got = 1'b0; claim = 1'b0; err = 1'b0; rd = '0;
        for (int k = 0; k < 20 && !got; k++) begin
            @(negedge clk);
            if (io_ready) begin
                got   = 1'b1;
                claim = io_claim;
                err   = io_err;
                rd    = io_rdata;
            end
        end
        io_req = 1'b0;
        ncfg   = cfg_count - c0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic got, claim, err;
        logic [31:0] rd;
        int ncfg;
        string tg;

        repeat (3) @(negedge clk);
        // R10: idle outputs during and after reset
        check(!io_ready && !cfg_req, "R10", {30'h0, io_ready, cfg_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_ready && !cfg_req, "R10", {30'h0, io_ready, cfg_req}, 32'h0);
        do_io(1'b0, 16'hCF8, 2'd2, 0, 0, 1'b0, got, claim, err, rd, ncfg);
        check(got && claim && rd == 32'h0, "R10", rd, 32'h0);
        do_io(1'b0, 16'hCFC, 2'd2, 0, 32'hDEAD_BEEF, 1'b0, got, claim, err, rd, ncfg);
        check(got && !claim && ncfg == 0, "R10", {31'h0, claim}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            tg = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            do_io(VECS[i].wr, VECS[i].port, VECS[i].sz, VECS[i].wdata, VECS[i].drd,
                  VECS[i].nf, got, claim, err, rd, ncfg);
            check(got, tg, {31'h0, got}, 32'h1);
            check(claim == VECS[i].eclaim && err == VECS[i].eerr, tg,
                  {30'h0, claim, err}, {30'h0, VECS[i].eclaim, VECS[i].eerr});
            check(rd == VECS[i].erd, tg, rd, VECS[i].erd);
            if (VECS[i].ebe != 4'h0) begin
                check(ncfg == 1 && cap_be == VECS[i].ebe && cap_wr == VECS[i].wr, tg,
                      {27'h0, cap_wr, cap_be}, {27'h0, VECS[i].wr, VECS[i].ebe});
                if (VECS[i].wr)
                    check(cap_wd == VECS[i].ewd, tg, cap_wd, VECS[i].ewd);
            end else begin
                check(ncfg == 0, tg, ncfg, 32'h0);
            end
        end

        // R4: target fields come from the selector; low bits forced to zero (R1)
        do_io(1'b1, 16'hCF8, 2'd2, 32'h80A5_C8FF, 0, 1'b0, got, claim, err, rd, ncfg);
        do_io(1'b0, 16'hCF8, 2'd2, 0, 0, 1'b0, got, claim, err, rd, ncfg);
        check(rd == 32'h80A5_C8FC, "R1", rd, 32'h80A5_C8FC);
        do_io(1'b0, 16'hCFD, 2'd0, 0, 32'h0000_6600, 1'b0, got, claim, err, rd, ncfg);
        check(ncfg == 1 && cap_tgt == {8'hA5, 8'hC8, 6'h3F}, "R4",
              {10'h0, cap_tgt}, {10'h0, 8'hA5, 8'hC8, 6'h3F});
        check(rd == 32'h66 && cap_be == 4'h2, "R8", rd, 32'h66);

        // R11: one ready pulse per access, request gone afterwards
        @(negedge clk);
        check(!io_ready && !cfg_req, "R11", {30'h0, io_ready, cfg_req}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule